// File: doc/BRIEF.md
# Multicore Inter-Processor Interrupt Mailbox

This block is a memory-mapped register file that lets cores post interrupts to each other. It serves 16 cores, arranged as 4 nodes of 4 cores. Every core owns a 32-bit pending word and a 32-bit enable word. It also has two write-only ports: one ORs bits into the pending word and one removes bits from it. Each core also has a 32-byte mailbox for a message payload. One interrupt line per core goes to the interrupt logic of that core.

A sender first places a payload in the target core's mailbox. It then writes a bit pattern to the target's set port, which raises the target's interrupt line. The receiver reads the pending word and the mailbox, then writes the bits it handled to its clear port. Its line drops only when no pending bit remains.

The block is accessed over a simple synchronous register bus. The bus has an address, read and write strobes, a size select (4 or 8 bytes), 64-bit write data and registered 64-bit read data. An access that is misaligned or that hits no register is flagged for one cycle and changes nothing.

Top module: `ipi_mailbox_regs`

## Requirements
- R1: After reset, every pending word, enable word and mailbox word is zero, all interrupt lines are low, and the read data and error flag are zero.
- R2: Node windows are placed at 0x3FF01000 + node × 2^44. Address bits [45:44] select the node and bits [9:8] select the core. The addressed core is core + 4 × node. Any address whose other bits above bit 9 differ from the base (bits [47:46] must be zero) is unmapped.
- R3: A write to slot offset 0x08 ORs write data bits [31:0] into the addressed core's pending word. It drives that core's interrupt line high from the next cycle, even when the data is zero. A pending read at offset 0x00 returns the pending word zero-extended.
- R4: A write to offset 0x0C clears the pending bits that are 1 in write data [31:0]. The interrupt line goes low only if the resulting pending word is zero. Otherwise it stays high.
- R5: A write to offset 0x00 changes nothing. Reads of offsets 0x08 and 0x0C return zero.
- R6: The enable word at offset 0x04 (4-byte access only) stores write data [31:0] and reads back zero-extended. It has no effect on any interrupt line.
- R7: The mailbox holds four 64-bit words at offsets 0x20, 0x28, 0x30 and 0x38. An 8-byte write stores all 64 bits and an 8-byte read returns them.
- R8: A 4-byte mailbox access at offset bit 2 = 0 touches bits [31:0] of the word, and at bit 2 = 1 touches bits [63:32]. Writes take write data [31:0]. Reads return the half in read data [31:0] with the upper half zero. The other half is unchanged.
- R9: An access whose offset is not a multiple of its size raises the error flag, changes no state, and a read returns zero.
- R10: An access to an unmapped offset (0x10–0x1F, 0x40–0xFF), to an address outside the windows, or with both strobes set raises the error flag, changes no state, and a read returns zero.
- R11: Read data and the error flag are registered and are valid in the cycle after the strobe. Read data holds until the next read. The error flag is high for exactly one cycle per faulty access.
- R12: An access to one core never changes the state or interrupt line of any other core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 48 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| bus_err | output | 1 | One-cycle error flag for a faulty access |
| ipi_irq | output | 16 | Interrupt line per core, index = core + 4 × node |

## Verification
A write updates state, including the interrupt lines, at the single rising edge on which its strobe is sampled. Read data and the error flag appear one edge after the strobe. The bench drives each access on a falling edge, holds it across one rising edge, and checks the error flag, the read data and all 16 interrupt lines at the following falling edge, where all of these results are due together. A bench-side model computed from the address arithmetic predicts every value. This allows full offset-by-size sweeps and a long pseudo-random access stream to be checked in every cycle.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;

    localparam int unsigned DATA_W = 64;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STATUS,
        ACC_ENABLE,
        ACC_SET,
        ACC_CLEAR,
        ACC_MBOX
    } acc_kind_e;

    localparam logic [7:0] OFF_STATUS = 8'h00;
    localparam logic [7:0] OFF_ENABLE = 8'h04;
    localparam logic [7:0] OFF_SET    = 8'h08;
    localparam logic [7:0] OFF_CLEAR  = 8'h0C;
    localparam logic [7:0] OFF_MBOX   = 8'h20;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
    import ipi_mbox_pkg::*;
#(
    parameter int unsigned     ADDR_W     = 48,
    parameter logic [47:0]     BASE_ADDR  = 48'h0000_3FF0_1000,
    parameter int unsigned     NODE_LSB   = 44,
    parameter int unsigned     NODE_W     = 2,
    parameter int unsigned     CORE_LSB   = 8,
    parameter int unsigned     CORE_W     = 2,
    parameter int unsigned     MBOX_WORDS = 4,
    parameter int unsigned     WORD_IDX_W = 2,
    localparam int unsigned    IDX_W      = NODE_W + CORE_W
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  rd,
    input  logic                  wr,
    input  logic                  size8,
    output logic                  acc_ok,
    output acc_kind_e             acc_kind,
    output logic [IDX_W-1:0]      acc_core,
    output logic [WORD_IDX_W-1:0] acc_word,
    output logic                  acc_hi
);

    localparam logic [ADDR_W-1:0] LOW_MASK  = (ADDR_W'(1) << (CORE_LSB + CORE_W)) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] NODE_MASK = ((ADDR_W'(1) << NODE_W) - ADDR_W'(1)) << NODE_LSB;
    localparam logic [ADDR_W-1:0] WIN_MASK  = ~(LOW_MASK | NODE_MASK);
    localparam int unsigned       MBOX_END  = int'(OFF_MBOX) + 8 * MBOX_WORDS;

    logic [7:0] off;
    logic [7:0] mb_rel;
    logic       win_ok;
    logic       aligned;

    always_comb begin
        off     = addr[7:0];
        mb_rel  = off - OFF_MBOX;
        win_ok  = ((addr ^ BASE_ADDR[ADDR_W-1:0]) & WIN_MASK) == '0;
        aligned = size8 ? (off[2:0] == 3'b000) : (off[1:0] == 2'b00);

        if (int'(off) >= int'(OFF_MBOX) && int'(off) < MBOX_END) begin
            acc_kind = ACC_MBOX;
        end else begin
            case (off)
                OFF_STATUS: acc_kind = ACC_STATUS;
                OFF_ENABLE: acc_kind = ACC_ENABLE;
                OFF_SET:    acc_kind = ACC_SET;
                OFF_CLEAR:  acc_kind = ACC_CLEAR;
                default:    acc_kind = ACC_NONE;
            endcase
        end

        acc_ok   = (rd ^ wr) && win_ok && aligned && (acc_kind != ACC_NONE);
        acc_core = {addr[NODE_LSB +: NODE_W], addr[CORE_LSB +: CORE_W]};
        acc_word = mb_rel[3 +: WORD_IDX_W];
        acc_hi   = off[2];
    end

endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
    import ipi_mbox_pkg::*;
#(
    parameter int unsigned STAT_W     = 32,
    parameter int unsigned MBOX_WORDS = 4,
    parameter int unsigned WORD_IDX_W = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  acc_kind_e                           kind,
    input  logic                                size8,
    input  logic [WORD_IDX_W-1:0]               word_idx,
    input  logic                                hi_half,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [STAT_W-1:0]                   status_o,
    output logic [STAT_W-1:0]                   enable_o,
    output logic                                irq_o,
    output logic [MBOX_WORDS-1:0][DATA_W-1:0]   mbox_o
);

    typedef struct packed {
        logic                              irq;
        logic [STAT_W-1:0]                 status;
        logic [STAT_W-1:0]                 enable;
        logic [MBOX_WORDS-1:0][DATA_W-1:0] mbox;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_en) begin
            case (kind)
                ACC_ENABLE: slot_d.enable = wdata[STAT_W-1:0];
                ACC_SET: begin
                    slot_d.status = slot_q.status | wdata[STAT_W-1:0];
                    slot_d.irq    = 1'b1;
                end
                ACC_CLEAR: begin
                    slot_d.status = slot_q.status & ~wdata[STAT_W-1:0];
                    if (slot_d.status == '0) begin
                        slot_d.irq = 1'b0;
                    end
                end
                ACC_MBOX: begin
                    if (size8) begin
                        slot_d.mbox[word_idx] = wdata;
                    end else if (hi_half) begin
                        slot_d.mbox[word_idx][DATA_W-1:DATA_W/2] = wdata[DATA_W/2-1:0];
                    end else begin
                        slot_d.mbox[word_idx][DATA_W/2-1:0] = wdata[DATA_W/2-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign status_o = slot_q.status;
    assign enable_o = slot_q.enable;
    assign irq_o    = slot_q.irq;
    assign mbox_o   = slot_q.mbox;

    // R3: a set write raises the line on the next cycle
    p_set_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_SET) |=> irq_o);

    // R4: pending bits never sit without a raised line
    p_pending_has_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != '0) |-> irq_o);

    // R4: the line only falls after a clear write
    p_fall_by_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(wr_en && kind == ACC_CLEAR));

    // R5: writes to the pending offset change nothing
    p_status_wr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_STATUS) |=> ($stable(status_o) && $stable(irq_o)));

    // R12: no write to this core, no change of its state
    p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(status_o) && $stable(enable_o) && $stable(mbox_o) && $stable(irq_o)));

endmodule

// File: rtl/ipi_mailbox_regs.sv
module ipi_mailbox_regs
    import ipi_mbox_pkg::*;
#(
    parameter int unsigned  ADDR_W     = 48,
    parameter logic [47:0]  BASE_ADDR  = 48'h0000_3FF0_1000,
    parameter int unsigned  NODE_LSB   = 44,
    parameter int unsigned  NODE_W     = 2,
    parameter int unsigned  CORE_LSB   = 8,
    parameter int unsigned  CORE_W     = 2,
    parameter int unsigned  STAT_W     = 32,
    parameter int unsigned  MBOX_WORDS = 4,
    localparam int unsigned N_CORES    = 1 << (NODE_W + CORE_W),
    localparam int unsigned IDX_W      = NODE_W + CORE_W,
    localparam int unsigned WORD_IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_size8,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic              bus_err,
    output logic [N_CORES-1:0] ipi_irq
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } port_t;

    port_t port_d, port_q;

    logic                  acc_ok;
    acc_kind_e             acc_kind;
    logic [IDX_W-1:0]      acc_core;
    logic [WORD_IDX_W-1:0] acc_word;
    logic                  acc_hi;

    logic [STAT_W-1:0]                 st_a   [N_CORES];
    logic [STAT_W-1:0]                 en_a   [N_CORES];
    logic [MBOX_WORDS-1:0][DATA_W-1:0] mb_a   [N_CORES];
    logic [DATA_W-1:0]                 rd_val;
    logic [DATA_W-1:0]                 sel_word;

    ipi_addr_decode #(
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR),
        .NODE_LSB   (NODE_LSB),
        .NODE_W     (NODE_W),
        .CORE_LSB   (CORE_LSB),
        .CORE_W     (CORE_W),
        .MBOX_WORDS (MBOX_WORDS),
        .WORD_IDX_W (WORD_IDX_W)
    ) i_decode (
        .addr     (bus_addr),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .size8    (bus_size8),
        .acc_ok   (acc_ok),
        .acc_kind (acc_kind),
        .acc_core (acc_core),
        .acc_word (acc_word),
        .acc_hi   (acc_hi)
    );

    for (genvar gi = 0; gi < N_CORES; gi++) begin : g_core
        logic core_wr;
        assign core_wr = bus_wr && acc_ok && (acc_core == IDX_W'(gi));

        ipi_core_slot #(
            .STAT_W     (STAT_W),
            .MBOX_WORDS (MBOX_WORDS),
            .WORD_IDX_W (WORD_IDX_W)
        ) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (core_wr),
            .kind     (acc_kind),
            .size8    (bus_size8),
            .word_idx (acc_word),
            .hi_half  (acc_hi),
            .wdata    (bus_wdata),
            .status_o (st_a[gi]),
            .enable_o (en_a[gi]),
            .irq_o    (ipi_irq[gi]),
            .mbox_o   (mb_a[gi])
        );
    end

    always_comb begin
        sel_word = mb_a[acc_core][acc_word];
        case (acc_kind)
            ACC_STATUS: rd_val = DATA_W'(st_a[acc_core]);
            ACC_ENABLE: rd_val = DATA_W'(en_a[acc_core]);
            ACC_MBOX: begin
                if (bus_size8) begin
                    rd_val = sel_word;
                end else if (acc_hi) begin
                    rd_val = DATA_W'(sel_word[DATA_W-1:DATA_W/2]);
                end else begin
                    rd_val = DATA_W'(sel_word[DATA_W/2-1:0]);
                end
            end
            default: rd_val = '0;
        endcase

        port_d     = port_q;
        port_d.err = (bus_rd || bus_wr) && !acc_ok;
        if (bus_rd) begin
            port_d.rdata = acc_ok ? rd_val : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign bus_rdata = port_q.rdata;
    assign bus_err   = port_q.err;

    // R11: the flag only follows an access
    p_err_needs_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> !bus_err);

    // R11: read data holds between reads
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R9 / R10: a refused read returns zero
    p_bad_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !acc_ok) |=> (bus_rdata == '0 && bus_err));

endmodule

// File: tb/test_ipi_mailbox_regs.sv
module test_ipi_mailbox_regs;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [47:0] BASE = 48'h0000_3FF0_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_size8 = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_err;
    logic [15:0] ipi_irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] seed = 32'h1234_5679;

    logic [31:0] m_st  [16];
    logic [31:0] m_en  [16];
    logic [63:0] m_mb  [16][4];
    logic [15:0] m_irq;

    always #10 clk = ~clk;

    ipi_mailbox_regs i_ipi_mailbox_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_size8 (bus_size8),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .ipi_irq   (ipi_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [47:0] mk(input int node, input int core, input int off);
        return BASE | (48'(node) << 44) | (48'(core) << 8) | 48'(off);
    endfunction

    // One access: driven at a falling edge, results checked at the next falling edge.
    task automatic access(input logic rd, input logic wr, input logic [47:0] a,
                          input logic s8, input logic [63:0] wd);
        logic [7:0]  off;
        int          id;
        logic        win;
        logic        algn;
        int          kind;
        logic        ok;
        logic [63:0] exp_rd;
        string       tag;
        string       itag;
        off  = a[7:0];
        id   = int'(a[9:8]) + 4 * int'(a[45:44]);
        win  = (a[47:46] == 2'b00) && (a[43:10] == BASE[43:10]);
        algn = s8 ? (off[2:0] == 0) : (off[1:0] == 0);
        if (off >= 8'h20 && off < 8'h40) kind = 5;
        else if (off == 8'h00) kind = 1;
        else if (off == 8'h04) kind = 2;
        else if (off == 8'h08) kind = 3;
        else if (off == 8'h0C) kind = 4;
        else kind = 0;
        ok = (rd ^ wr) && win && algn && (kind != 0);
        exp_rd = '0;
        if (ok) begin
            case (kind)
                1: exp_rd = {32'h0, m_st[id]};
                2: exp_rd = {32'h0, m_en[id]};
                5: exp_rd = s8 ? m_mb[id][off[4:3]] :
                            (off[2] ? {32'h0, m_mb[id][off[4:3]][63:32]}
                                    : {32'h0, m_mb[id][off[4:3]][31:0]});
                default: exp_rd = '0;
            endcase
        end
        if (!ok) tag = ((rd ^ wr) && win && kind != 0 && !algn) ? "R9 misaligned" : "R10 unmapped";
        else case (kind)
            1: tag = "R3 pending read";
            2: tag = "R6 enable";
            3, 4: tag = "R5 set/clear port";
            default: tag = s8 ? "R7 mailbox 8-byte" : "R8 mailbox 4-byte";
        endcase
        itag = "R12 irq lines";
        if (ok && wr) begin
            case (kind)
                2: m_en[id] = wd[31:0];
                3: begin m_st[id] = m_st[id] | wd[31:0]; m_irq[id] = 1'b1; itag = "R3 irq set"; end
                4: begin
                    m_st[id] = m_st[id] & ~wd[31:0];
                    if (m_st[id] == 0) m_irq[id] = 1'b0;
                    itag = "R4 irq clear";
                end
                5: begin
                    if (s8) m_mb[id][off[4:3]] = wd;
                    else if (off[2]) m_mb[id][off[4:3]][63:32] = wd[31:0];
                    else m_mb[id][off[4:3]][31:0] = wd[31:0];
                end
                default: ;
            endcase
        end
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_size8 = s8; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        chk({tag, " err"}, 64'(bus_err), 64'(!ok));
        if (rd) chk({tag, " rdata"}, bus_rdata, exp_rd);
        chk(itag, 64'(ipi_irq), 64'(m_irq));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R11 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_st[i] = '0; m_en[i] = '0;
            for (int w = 0; w < 4; w++) m_mb[i][w] = '0;
        end
        m_irq = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports
        chk("R1 irq after reset", 64'(ipi_irq), 64'h0);
        chk("R1 err after reset", 64'(bus_err), 64'h0);
        chk("R1 rdata after reset", bus_rdata, 64'h0);
        for (int i = 0; i < 16; i++) begin
            access(1, 0, mk(i / 4, i % 4, 8'h00), 0, '0);
            access(1, 0, mk(i / 4, i % 4, 8'h04), 0, '0);
            for (int w = 0; w < 4; w++) access(1, 0, mk(i / 4, i % 4, 8'h20 + 8 * w), 1, '0);
        end

        // R2 / R6 / R12: distinct enable per core, read back across all cores
        for (int i = 0; i < 16; i++) access(0, 1, mk(i / 4, i % 4, 8'h04), 0, {32'hDEAD_0000, 32'hE000_0000 | 32'(i)});
        for (int i = 0; i < 16; i++) access(1, 0, mk(i / 4, i % 4, 8'h04), 0, '0);

        // R7: 8-byte mailbox words
        for (int i = 0; i < 16; i++)
            for (int w = 0; w < 4; w++) access(0, 1, mk(i / 4, i % 4, 8'h20 + 8 * w), 1, {rnd(), rnd()});
        for (int i = 0; i < 16; i++)
            for (int w = 0; w < 4; w++) access(1, 0, mk(i / 4, i % 4, 8'h20 + 8 * w), 1, '0);

        // R8: 4-byte halves
        for (int i = 0; i < 16; i += 5)
            for (int h = 0; h < 8; h++) begin
                access(0, 1, mk(i / 4, i % 4, 8'h20 + 4 * h), 0, {rnd(), rnd()});
                access(1, 0, mk(i / 4, i % 4, 8'h20 + 8 * (h / 2)), 1, '0);
                access(1, 0, mk(i / 4, i % 4, 8'h20 + 4 * (h ^ 1)), 0, '0);
            end

        // R2: node 2 core 1 is flat index 9
        access(0, 1, mk(2, 1, 8'h08), 0, 64'h1);
        chk("R2 flat index line", 64'(ipi_irq), 64'h0200);

        // R3 / R4 on core 5
        access(0, 1, mk(1, 1, 8'h08), 1, 64'hFFFF_FFFF_0000_00F0);
        access(1, 0, mk(1, 1, 8'h00), 1, '0);
        access(0, 1, mk(1, 1, 8'h0C), 0, 64'h10);
        chk("R4 line stays with bits left", 64'(ipi_irq[5]), 64'h1);
        // R6: enable changes no line
        access(0, 1, mk(1, 1, 8'h04), 0, 64'h0);
        // R5: pending offset write ignored, port reads zero
        access(0, 1, mk(1, 1, 8'h00), 0, 64'hFFFF_FFFF);
        access(1, 0, mk(1, 1, 8'h00), 0, '0);
        access(1, 0, mk(1, 1, 8'h08), 0, '0);
        access(1, 0, mk(1, 1, 8'h0C), 1, '0);
        access(0, 1, mk(1, 1, 8'h0C), 0, 64'hE0);
        chk("R4 line drops at zero", 64'(ipi_irq[5]), 64'h0);
        // R3: set with zero data still raises; zero clear then drops
        access(0, 1, mk(3, 3, 8'h08), 0, 64'h0);
        chk("R3 zero set raises line", 64'(ipi_irq[15]), 64'h1);
        access(0, 1, mk(3, 3, 8'h0C), 0, 64'h0);
        chk("R4 zero clear drops line", 64'(ipi_irq[15]), 64'h0);

        // R11: read data hold and one-cycle error
        access(1, 0, mk(0, 2, 8'h04), 0, '0);
        access(0, 1, mk(0, 2, 8'h20), 1, 64'hA5A5_5A5A_0F0F_F0F0);
        chk("R11 rdata holds over write", bus_rdata, {32'h0, m_en[2]});
        access(0, 1, mk(0, 2, 8'h11), 0, 64'h1);
        @(negedge clk);
        chk("R11 err one cycle", 64'(bus_err), 64'h0);

        // R9: full offset-by-size sweep on one core
        for (int off = 0; off < 64; off++)
            for (int s = 0; s < 2; s++) begin
                access(0, 1, mk(0, 3, off), s[0], {rnd(), rnd()});
                access(1, 0, mk(0, 3, off), s[0], '0);
            end

        // R10: unmapped offsets, foreign windows, both strobes
        for (int off = 64; off < 256; off += 4)
            for (int s = 0; s < 2; s++) begin
                access(0, 1, mk(2, 2, off), s[0], {rnd(), rnd()});
                access(1, 0, mk(2, 2, off), s[0], '0);
            end
        access(0, 1, mk(1, 0, 8'h08) ^ 48'h0000_0010_0000, 0, 64'hFF);
        access(0, 1, mk(1, 0, 8'h08) | 48'h4000_0000_0000, 0, 64'hFF);
        access(0, 1, mk(1, 0, 8'h08) ^ 48'h0000_0000_0400, 0, 64'hFF);
        access(1, 1, mk(1, 0, 8'h04), 0, 64'h1234);
        access(1, 0, mk(1, 0, 8'h04), 0, '0);

        // Pseudo-random stream over all cores and the mapped range
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = rnd();
            access(r[0], ~r[0], mk(int'(r[3:2]), int'(r[5:4]), int'(r[13:8] & 6'h3F)),
                   r[6], (r[7] ? 64'hFFFF_FFFF_FFFF_FFFF : {rnd(), rnd()}));
        end
        for (int i = 0; i < 16; i++) access(1, 0, mk(i / 4, i % 4, 8'h00), 0, '0);

        finish_run();
    end

endmodule